// File: doc/BRIEF.md
# Serially Configured Four-LUT Logic Slice

This block is one logic tile of a small programmable fabric. Four 4-input lookup tables share a 4-bit index bus arriving from the north. A second 4-bit bus arrives from the south. The tables drive a 4-bit result bus. Each result bit can come straight from its table or from a flip-flop on the fabric clock. A per-slice adder mode turns the four bits into a 4+4 bit sum of the two buses, with a carry in and a carry out on the spare priority lines. A cascade path lets a slice take one bit from its west neighbour and hand its top table's output to its east neighbour. Two tables in adjacent slices then form one function of five inputs without going through general routing.

The contents come in through a serial chain of 8-bit segments. The chain is clocked by the fabric clock while a shift strobe is high, and its far end is brought out so slices can be daisy-chained. The chain is a shadow copy. Nothing it holds changes the logic until a latch strobe copies it into the active configuration. A fabric can therefore stream a new image through every slice and switch all of them over on the same edge.

Top module: `logic_slice`

## Requirements
- R1: The chain is 80 bits long (ten 8-bit segments). At each rising edge with cfgShift high, cfgIn enters chain position 0, every bit moves up one position, and cfgOut shows position 79. A word shifted in most significant bit first therefore leaves its bit k at position k. cfgOut does not change on edges where cfgShift is low.
- R2: Shifting alone leaves outBus, carryOut and cascadeOut unchanged. A rising edge with cfgLatch high copies chain positions 0 to 73 into the active configuration, which is in force from that edge on.
- R3: LUT i (i = 0..3) holds active bits 16i+15 down to 16i. With registering and cascading off for that bit and the adder off, outBus[i] is the table bit whose index is the value on northIn, combinationally. cascadeOut is always LUT 3's table bit at northIn.
- R4: When active bit 64+i is set, outBus[i] comes from a flip-flop that loads that bit's combinational value at every rising edge. It therefore changes only at edges.
- R5: A synchronous reset clears the chain, the active configuration and the result flip-flops. In the cycle after a reset edge, outBus, carryOut and cfgOut are all 0.
- R6: When active bit 72 is set, outBus is the low four bits of northIn + southIn + cin and carryOut is bit 4 of that sum. The table and cascade selections have no effect in this mode. When bit 72 is clear, carryOut is 0.
- R7: cin equals carryIn when active bit 73 is set, and 0 when it is clear.
- R8: Outside adder mode, when active bit 68+i is set and southIn[i] is 1, outBus[i] takes cascadeIn instead of LUT i's output.
- R9: With LUT i holding bit i of (index + 1) mod 16, all four register bits set, and outBus fed back to northIn, outBus steps by one each clock and wraps from 15 to 0.
- R10: On an edge where cfgShift and cfgLatch are both high, the active configuration receives the chain contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; also clocks the configuration chain |
| rst | input | 1 | Synchronous reset, active high |
| cfgShift | input | 1 | Moves the configuration chain one place per edge |
| cfgLatch | input | 1 | Copies the chain into the active configuration |
| cfgIn | input | 1 | Serial configuration data in |
| cfgOut | output | 1 | Serial configuration data out, for the next slice |
| northIn | input | 4 | North bus; table index and first adder operand |
| southIn | input | 4 | South bus; cascade selects and second adder operand |
| carryIn | input | 1 | Carry in from a priority line |
| carryOut | output | 1 | Carry out onto a priority line |
| cascadeIn | input | 1 | Cascade bit from the west neighbour |
| cascadeOut | output | 1 | LUT 3 table output to the east neighbour |
| outBus | output | 4 | Result bus |

## Verification
Table lookups, the sum, the carry and the cascade select settle within the cycle in which their inputs change. Registered bits, chain shifts, latches and resets show up one rising edge later. Every stimulus is applied just after a falling edge and held, and its expected item is compared at the next falling edge, after exactly one rising edge. That single sampling point covers both the combinational and the one-edge results. To show the one-edge lag of registered bits against combinational bits, one check samples outBus halfway between a mid-cycle input change and the following edge.

// File: rtl/slice_pkg.sv
package slice_pkg;
  localparam int BUS_W     = 4;
  localparam int NUM_LUT   = BUS_W;
  localparam int LUT_IN    = BUS_W;
  localparam int SEG_W     = 8;
  localparam int TBL_W     = 1 << LUT_IN;
  localparam int TT_BITS   = NUM_LUT * TBL_W;
  localparam int REG_BASE  = TT_BITS;
  localparam int CASC_BASE = REG_BASE + NUM_LUT;
  localparam int ADD_BIT   = CASC_BASE + NUM_LUT;
  localparam int CIN_BIT   = ADD_BIT + 1;
  localparam int CFG_BITS  = CIN_BIT + 1;
  localparam int NUM_SEG   = (CFG_BITS + SEG_W - 1) / SEG_W;
  localparam int CHAIN_W   = NUM_SEG * SEG_W;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
  } cfgStrobe_t;

  // field order matches the active configuration, MSB first
  typedef struct packed {
    logic               carryInUse;
    logic               addMode;
    logic [NUM_LUT-1:0] cascadeEn;
    logic [NUM_LUT-1:0] regEn;
  } sliceMode_t;
endpackage

// File: rtl/slice_lut_cell.sv
module slice_lut_cell #(
  parameter int SEL_W = 4,
  parameter int TBL_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TBL_W-1:0] truthTbl,
  input  logic [SEL_W-1:0] index,
  input  logic             addMode,
  input  logic             addBit,
  input  logic             cascadeEn,
  input  logic             cascadeSel,
  input  logic             cascadeIn,
  input  logic             regEn,
  output logic             lutRaw,
  output logic             cellOut
);
  logic pick;
  logic heldBit;

  assign lutRaw = truthTbl[index];

  always_comb begin
    if (addMode)
      pick = addBit;
    else if (cascadeEn && cascadeSel)
      pick = cascadeIn;
    else
      pick = lutRaw;
  end

  always_ff @(posedge clk) begin
    if (rst) heldBit <= 1'b0;
    else     heldBit <= pick;
  end

  assign cellOut = regEn ? heldBit : pick;
endmodule

// File: rtl/slice_cfg_ctrl.sv
module slice_cfg_ctrl
  import slice_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  cfgStrobe_t         strobe,
  input  logic               cfgIn,
  output logic               cfgOut,
  output logic [TT_BITS-1:0] truthTables,
  output sliceMode_t         mode
);
  logic [CHAIN_W-1:0]  shadow;
  logic [NUM_SEG:0]    link;
  logic [CFG_BITS-1:0] active;

  assign link[0] = cfgIn;

  // daisy-chained 8-bit segments
  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (rst)
        shadow[g*SEG_W +: SEG_W] <= '0;
      else if (strobe.shiftEn)
        shadow[g*SEG_W +: SEG_W] <= {shadow[g*SEG_W +: SEG_W-1], link[g]};
    end
    assign link[g+1] = shadow[g*SEG_W + SEG_W - 1];
  end

  assign cfgOut = link[NUM_SEG];

  always_ff @(posedge clk) begin
    if (rst)
      active <= '0;
    else if (strobe.latchEn)
      active <= shadow[CFG_BITS-1:0];
  end

  assign truthTables = active[TT_BITS-1:0];
  assign mode        = sliceMode_t'(active[CFG_BITS-1:REG_BASE]);
endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [TT_BITS-1:0] truthTables,
  input  sliceMode_t         mode,
  input  logic [BUS_W-1:0]   northIn,
  input  logic [BUS_W-1:0]   southIn,
  input  logic               carryIn,
  input  logic               cascadeIn,
  output logic [BUS_W-1:0]   outBus,
  output logic               carryOut,
  output logic               cascadeOut
);
  localparam int SUM_W = BUS_W + 1;

  logic             cin;
  logic [SUM_W-1:0] sum;
  logic [NUM_LUT-1:0] rawVec;

  assign cin = mode.carryInUse & carryIn;
  assign sum = {1'b0, northIn} + {1'b0, southIn} + SUM_W'(cin);

  for (genvar i = 0; i < NUM_LUT; i++) begin : gLut
    slice_lut_cell #(.SEL_W(LUT_IN), .TBL_W(TBL_W)) uCell (
      .clk       (clk),
      .rst       (rst),
      .truthTbl  (truthTables[i*TBL_W +: TBL_W]),
      .index     (northIn),
      .addMode   (mode.addMode),
      .addBit    (sum[i]),
      .cascadeEn (mode.cascadeEn[i]),
      .cascadeSel(southIn[i]),
      .cascadeIn (cascadeIn),
      .regEn     (mode.regEn[i]),
      .lutRaw    (rawVec[i]),
      .cellOut   (outBus[i])
    );
  end

  assign carryOut   = mode.addMode & sum[BUS_W];
  assign cascadeOut = rawVec[NUM_LUT-1];
endmodule

// File: rtl/logic_slice.sv
module logic_slice
  import slice_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgShift,
  input  logic             cfgLatch,
  input  logic             cfgIn,
  output logic             cfgOut,
  input  logic [BUS_W-1:0] northIn,
  input  logic [BUS_W-1:0] southIn,
  input  logic             carryIn,
  output logic             carryOut,
  input  logic             cascadeIn,
  output logic             cascadeOut,
  output logic [BUS_W-1:0] outBus
);
  cfgStrobe_t         strobe;
  sliceMode_t         mode;
  logic [TT_BITS-1:0] truthTables;

  assign strobe.shiftEn = cfgShift;
  assign strobe.latchEn = cfgLatch;

  slice_cfg_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .cfgIn      (cfgIn),
    .cfgOut     (cfgOut),
    .truthTables(truthTables),
    .mode       (mode)
  );

  slice_datapath uData (
    .clk        (clk),
    .rst        (rst),
    .truthTables(truthTables),
    .mode       (mode),
    .northIn    (northIn),
    .southIn    (southIn),
    .carryIn    (carryIn),
    .cascadeIn  (cascadeIn),
    .outBus     (outBus),
    .carryOut   (carryOut),
    .cascadeOut (cascadeOut)
  );
endmodule

// File: rtl/slice_chk.sv
module slice_chk
  import slice_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfgShift,
  input logic             cfgLatch,
  input logic             cfgOut,
  input logic [BUS_W-1:0] outBus,
  input logic             carryOut,
  input sliceMode_t       mode
);
  // R1
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgShift |=> $stable(cfgOut));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgLatch |=> $stable(mode));

  // R6
  carry_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode.addMode |-> !carryOut);

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (outBus == '0 && !cfgOut && !carryOut));
endmodule

bind logic_slice slice_chk uChk (
  .clk     (clk),
  .rst     (rst),
  .cfgShift(cfgShift),
  .cfgLatch(cfgLatch),
  .cfgOut  (cfgOut),
  .outBus  (outBus),
  .carryOut(carryOut),
  .mode    (mode)
);

// File: tb/tb_logic_slice.sv
module tb_logic_slice;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgShift = 1'b0, cfgLatch = 1'b0, cfgIn = 1'b0;
  logic cfgOut;
  logic [3:0] northIn = 4'h0, southIn = 4'h0;
  logic carryIn = 1'b0, cascadeIn = 1'b0;
  logic carryOut, cascadeOut;
  logic [3:0] outBus;

  always #10 clk = ~clk;

  logic_slice dut (
    .clk(clk), .rst(rst), .cfgShift(cfgShift), .cfgLatch(cfgLatch),
    .cfgIn(cfgIn), .cfgOut(cfgOut), .northIn(northIn), .southIn(southIn),
    .carryIn(carryIn), .carryOut(carryOut), .cascadeIn(cascadeIn),
    .cascadeOut(cascadeOut), .outBus(outBus)
  );

  typedef struct {
    logic [3:0] out;
    logic       co;
    logic       casc;
    logic       cfgO;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  exp_t monItem;
  exp_t lastExp;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [79:0] mShadow = '0;
  logic [73:0] mActive = '0;

  // returns {casc, co, out}
  function automatic logic [5:0] evalSlice(logic [73:0] a, logic [3:0] n,
                                          logic [3:0] s, logic ci, logic casci);
    logic [4:0] sum;
    logic [3:0] o;
    sum = {1'b0, n} + {1'b0, s} + {4'b0, a[73] & ci};
    for (int i = 0; i < 4; i++) begin
      if (a[72])                  o[i] = sum[i];
      else if (a[68+i] && s[i])   o[i] = casci;
      else                        o[i] = a[16*i + int'(n)];
    end
    return {a[48 + int'(n)], a[72] & sum[4], o};
  endfunction

  function automatic logic [79:0] mkCfg(logic [15:0] t0, t1, t2, t3,
                                        logic [3:0] rg, cs, logic add, ciu);
    return {6'b0, ciu, add, cs, rg, t3, t2, t1, t0};
  endfunction

  function automatic logic [15:0] ctrTbl(int bitNo);
    logic [15:0] t;
    for (int n = 0; n < 16; n++) t[n] = ((n + 1) >> bitNo) & 1;
    return t;
  endfunction

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      monItem = sbq.pop_front();
      vectors++;
      if ({outBus, carryOut, cascadeOut, cfgOut} !==
          {monItem.out, monItem.co, monItem.casc, monItem.cfgO}) begin
        fails++;
        $display("FAIL %s: out=%h co=%b casc=%b cfgOut=%b expected out=%h co=%b casc=%b cfgOut=%b",
                 monItem.tag, outBus, carryOut, cascadeOut, cfgOut,
                 monItem.out, monItem.co, monItem.casc, monItem.cfgO);
      end
    end
  end

  // driver: apply one cycle of stimulus and push what must appear after the next edge
  task automatic cycle(input logic [3:0] n, s, input logic ci, casci,
                       input logic sh, shBit, lat, rs, input string tag);
    logic [73:0] oldAct;
    logic [5:0]  eOld, eNew;
    exp_t        e;
    oldAct = mActive;
    northIn = n; southIn = s; carryIn = ci; cascadeIn = casci;
    cfgShift = sh; cfgIn = shBit; cfgLatch = lat; rst = rs;
    if (rs) begin
      mShadow = '0;
      mActive = '0;
    end else begin
      if (lat) mActive = mShadow[73:0];
      if (sh)  mShadow = {mShadow[78:0], shBit};
    end
    eOld = evalSlice(oldAct, n, s, ci, casci);
    eNew = evalSlice(mActive, n, s, ci, casci);
    for (int i = 0; i < 4; i++)
      e.out[i] = mActive[64+i] ? (rs ? 1'b0 : eOld[i]) : eNew[i];
    e.co = eNew[4];
    e.casc = eNew[5];
    e.cfgO = mShadow[79];
    e.tag = tag;
    sbq.push_back(e);
    lastExp = e;
    @(negedge clk);
    #1;
  endtask

  task automatic drv(input logic [3:0] n, s, input logic ci, casci, input string tag);
    cycle(n, s, ci, casci, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic loadWord(input logic [79:0] w, input string tag);
    for (int i = 79; i >= 0; i--)
      cycle(4'h9, 4'h3, 1'b0, 1'b1, 1'b1, w[i], 1'b0, 1'b0, tag);
  endtask

  task automatic latchCfg(input string tag);
    cycle(4'h9, 4'h3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    logic [79:0] w;
    // R5 reset state
    cycle(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 reset state");
    cycle(4'hF, 4'hF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R5 reset state");

    // R1 chain order, then R3 table lookup
    w = mkCfg(16'h6996, 16'hFF00, 16'h8000, 16'hFFFE, 4'h0, 4'h0, 1'b0, 1'b0);
    loadWord(w, "R1 chain shift");
    latchCfg("R2 latch");
    for (int n = 0; n < 16; n++)
      drv(4'(n), 4'(n) ^ 4'h5, 1'b1, n[0], "R3 lut lookup");

    // R2 shadow isolation, R10 shift with latch, R9 counter, R4 registers
    w = mkCfg(ctrTbl(0), ctrTbl(1), ctrTbl(2), ctrTbl(3), 4'hF, 4'h0, 1'b0, 1'b0);
    loadWord(w, "R2 outputs hold while shifting");
    cycle(4'h9, 4'h3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R10 shift and latch together");
    for (int k = 0; k < 20; k++)
      drv(lastExp.out, 4'h0, 1'b0, 1'b0, "R9 counter");

    // R4 mixed register enables, identity tables
    w = mkCfg(16'hAAAA, 16'hCCCC, 16'hF0F0, 16'hFF00, 4'b0101, 4'h0, 1'b0, 1'b0);
    loadWord(w, "R1 chain shift");
    latchCfg("R2 latch");
    drv(4'h0, 4'h0, 1'b0, 1'b0, "R4 registered bits");
    northIn = 4'hF;
    #4;
    vectors++;
    if (outBus !== 4'b1010) begin
      fails++;
      $display("FAIL R4 before edge: out=%h expected out=%h", outBus, 4'b1010);
    end
    drv(4'hF, 4'h0, 1'b0, 1'b0, "R4 registered bits");
    drv(4'h6, 4'h0, 1'b0, 1'b0, "R4 registered bits");

    // R6 adder with R7 carry-in in use; R8 cascade ignored in adder mode
    w = mkCfg(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'h0, 4'hF, 1'b1, 1'b1);
    loadWord(w, "R1 chain shift");
    latchCfg("R2 latch");
    drv(4'h3, 4'h4, 1'b0, 1'b1, "R6 add");
    drv(4'hF, 4'hF, 1'b1, 1'b1, "R6 add with carry");
    drv(4'h8, 4'h8, 1'b0, 1'b0, "R6 add overflow");
    drv(4'h9, 4'h6, 1'b1, 1'b1, "R7 carry in used");
    drv(4'hF, 4'h0, 1'b1, 1'b0, "R7 carry in used");

    // R7 carry-in disabled
    w = mkCfg(16'h0000, 16'h0000, 16'h0000, 16'h0000, 4'h0, 4'h0, 1'b1, 1'b0);
    loadWord(w, "R1 chain shift");
    latchCfg("R2 latch");
    drv(4'h7, 4'h8, 1'b1, 1'b0, "R7 carry in ignored");
    drv(4'hF, 4'h1, 1'b1, 1'b0, "R7 carry in ignored");

    // R8 cascade select
    w = mkCfg(16'h0000, 16'hFFFF, 16'h0000, 16'hAAAA, 4'h0, 4'b0111, 1'b0, 1'b0);
    loadWord(w, "R1 chain shift");
    latchCfg("R2 latch");
    drv(4'h1, 4'b0001, 1'b0, 1'b1, "R8 cascade");
    drv(4'h2, 4'b0110, 1'b0, 1'b0, "R8 cascade");
    drv(4'h3, 4'b1111, 1'b0, 1'b1, "R8 cascade");
    drv(4'h0, 4'b0000, 1'b0, 1'b1, "R8 cascade");

    // R5 reset after configuration
    cycle(4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 reset clears");
    drv(4'hF, 4'hF, 1'b1, 1'b1, "R5 reset clears");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule